// File: doc/BRIEF.md
# Serial Eye-Pattern Data Serializer

This block drives an oscilloscope eye display through external serial-to-parallel converters and DACs. Every frame it reads one signed 9-bit X/Y sample pair from an internal RAM read port and shifts both values out at the same time on two serial lines, most significant (sign) bit first. A bit clock goes with the two lines, and a slower word clock marks when the external converters should latch the assembled words. The RAM location that is displayed comes from a host-writable address register. The default location is 17h, the rotated equalizer output, which gives the normal eye picture.

Both clocks are produced from the system clock by clock-enable counters. One bit period lasts `CLK_PER_BIT` system cycles, and one frame lasts 24 bit periods. Nine data slots come first. The lines are then held low for the remaining fifteen slots. The word clock rises when data slot nine ends and stays high for half a frame. A new address from the host is copied to the RAM port only at the frame boundary, so a displayed word always comes from a single RAM location.

Top module: `eye_pattern_serializer`

## Requirements
- R1: While reset is held and right after it, `bit_clk`, `word_clk`, `ser_x` and `ser_y` are 0, and `addr_q` and `src_addr` both hold 17h.
- R2: `bit_clk` has a period of `CLK_PER_BIT` system cycles and is high for the first `CLK_PER_BIT/2` of those cycles.
- R3: `ser_x` and `ser_y` change only in the system cycle in which `bit_clk` goes from 0 to 1.
- R4: A frame is 24 bit-clock periods. In slots 0 to 8 the lines carry sample bits 8 down to 0 (bit 8, the sign, in slot 0). In slots 9 to 23 both lines are 0.
- R5: `word_clk` rises on the same cycle as the `bit_clk` rise that begins slot 9, and it falls on the rise that begins slot 21, so it is high for 12 bit periods of every 24.
- R6: `ser_x` carries the `src_x` sample and `ser_y` carries the `src_y` sample. Both samples are taken from the same read of the port, in the cycle in which slot 0 begins.
- R7: A cycle with `addr_we` high stores `addr_wdata` in the address register, and `addr_q` shows it from the next cycle on.
- R8: `src_addr` changes only on the `bit_clk` rise that begins slot 23, and it then takes the value of the address register. A write made before that point in a frame therefore appears in the data of the next frame.
- R9: A write made during slot 23 does not change the next frame. Its data first appears in the frame after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Host write strobe for the address register |
| addr_wdata | input | ADDR_W | Host write data for the address register |
| addr_q | output | ADDR_W | Current address register value |
| src_addr | output | ADDR_W | Address applied to the sample RAM read port |
| src_x | input | WORD_BITS | Signed X sample read at `src_addr` (same cycle) |
| src_y | input | WORD_BITS | Signed Y sample read at `src_addr` (same cycle) |
| bit_clk | output | 1 | Serial bit clock |
| word_clk | output | 1 | Word latch clock |
| ser_x | output | 1 | Serial X stream |
| ser_y | output | 1 | Serial Y stream |

## Verification
The checker assumes that the sample RAM is an asynchronous read port, so that `src_x` and `src_y` are valid in the same cycle that `src_addr` is, and that the host changes the address only through `addr_we`. The bench drives the read port from a pure function of `src_addr`. It writes the address only at chosen bit slots, one slot in the middle of a frame and the last slot of a frame, so the expected data for each frame follows directly from R8 and R9.

// File: rtl/eye_ser_pkg.sv
package eye_ser_pkg;

  localparam int unsigned EYE_WORD_BITS   = 9;
  localparam int unsigned EYE_FRAME_SLOTS = 24;
  localparam int unsigned EYE_ADDR_W      = 8;

  // Per-bit-period strobes from the frame sequencer
  typedef struct packed {
    logic tick;      // bit clock rises at the next edge
    logic load;      // next slot is slot 0: capture a new sample pair
    logic addr_upd;  // next slot is the last slot: copy the host address
  } eye_strobe_t;

endpackage

// File: rtl/eye_tick_gen.sv
module eye_tick_gen #(
  parameter int unsigned CLK_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic bit_clk_o
);

  localparam int unsigned PW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(CLK_PER_BIT - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(CLK_PER_BIT / 2);

  logic [PW-1:0] phase_q, phase_d;
  logic          bclk_q, bclk_d;

  always_comb begin
    tick_o  = (phase_q == PH_LAST);
    phase_d = tick_o ? '0 : phase_q + 1'b1;
    bclk_d  = (phase_d < PH_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LAST;
      bclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bclk_q  <= bclk_d;
    end
  end

  assign bit_clk_o = bclk_q;

endmodule

// File: rtl/eye_frame_ctl.sv
module eye_frame_ctl
  import eye_ser_pkg::*;
#(
  parameter int unsigned FRAME_SLOTS = EYE_FRAME_SLOTS,
  parameter int unsigned WORD_BITS   = EYE_WORD_BITS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  output eye_strobe_t strobe_o,
  output logic        word_clk_o
);

  localparam int unsigned SW = $clog2(FRAME_SLOTS + 1);
  localparam logic [SW-1:0] SL_LAST = SW'(FRAME_SLOTS - 1);
  localparam logic [SW-1:0] W_ON    = SW'(WORD_BITS);
  localparam logic [SW-1:0] W_OFF   = SW'(WORD_BITS + FRAME_SLOTS / 2);

  logic [SW-1:0] slot_q, slot_d;
  logic          wclk_q, wclk_d;

  always_comb begin
    slot_d = slot_q;
    wclk_d = wclk_q;
    if (tick_i) begin
      slot_d = (slot_q == SL_LAST) ? '0 : slot_q + 1'b1;
      wclk_d = (slot_d >= W_ON) && (slot_d < W_OFF);
    end
    strobe_o.tick     = tick_i;
    strobe_o.load     = tick_i && (slot_q == SL_LAST);
    strobe_o.addr_upd = tick_i && (slot_q == SL_LAST - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SL_LAST;
      wclk_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      wclk_q <= wclk_d;
    end
  end

  assign word_clk_o = wclk_q;

endmodule

// File: rtl/eye_shifter.sv
module eye_shifter
  import eye_ser_pkg::*;
#(
  parameter int unsigned WORD_BITS = EYE_WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  eye_strobe_t          strobe_i,
  input  logic [WORD_BITS-1:0] sample_i,
  output logic                 ser_o
);

  logic [WORD_BITS-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (strobe_i.load)
      sh_d = sample_i;
    else if (strobe_i.tick)
      sh_d = {sh_q[WORD_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_o = sh_q[WORD_BITS-1];

endmodule

// File: rtl/eye_pattern_serializer.sv
module eye_pattern_serializer
  import eye_ser_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 4,
  parameter int unsigned WORD_BITS   = EYE_WORD_BITS,
  parameter int unsigned FRAME_SLOTS = EYE_FRAME_SLOTS,
  parameter int unsigned ADDR_W      = EYE_ADDR_W,
  parameter logic [ADDR_W-1:0] ADDR_RST = ADDR_W'(8'h17)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_we,
  input  logic [ADDR_W-1:0]    addr_wdata,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [ADDR_W-1:0]    src_addr,
  input  logic [WORD_BITS-1:0] src_x,
  input  logic [WORD_BITS-1:0] src_y,
  output logic                 bit_clk,
  output logic                 word_clk,
  output logic                 ser_x,
  output logic                 ser_y
);

  localparam int unsigned NSTREAM = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // host address register and frame-aligned source address
  logic [ADDR_W-1:0] host_q, host_d, src_q, src_d;
  eye_strobe_t       strobe;
  logic              tick;

  always_comb begin
    host_d = addr_we ? addr_wdata : host_q;
    src_d  = strobe.addr_upd ? host_q : src_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      host_q <= ADDR_RST;
      src_q  <= ADDR_RST;
    end else begin
      host_q <= host_d;
      src_q  <= src_d;
    end
  end

  assign addr_q   = host_q;
  assign src_addr = src_q;

  eye_tick_gen #(.CLK_PER_BIT(CLK_PER_BIT)) u_tick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_o    (tick),
    .bit_clk_o (bit_clk)
  );

  eye_frame_ctl #(.FRAME_SLOTS(FRAME_SLOTS), .WORD_BITS(WORD_BITS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (tick),
    .strobe_o   (strobe),
    .word_clk_o (word_clk)
  );

  logic [WORD_BITS-1:0] samp [NSTREAM];
  logic [NSTREAM-1:0]   ser;

  assign samp[0] = src_x;
  assign samp[1] = src_y;

  for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
    eye_shifter #(.WORD_BITS(WORD_BITS)) u_sh (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .strobe_i (strobe),
      .sample_i (samp[g]),
      .ser_o    (ser[g])
    );
  end

  assign ser_x = ser[0];
  assign ser_y = ser[1];

endmodule

// File: rtl/eye_ser_checker.sv
module eye_ser_checker #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WORD_BITS = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 addr_we,
  input logic [ADDR_W-1:0]    addr_wdata,
  input logic [ADDR_W-1:0]    addr_q,
  input logic [ADDR_W-1:0]    src_addr,
  input logic [WORD_BITS-1:0] src_x,
  input logic [WORD_BITS-1:0] src_y,
  input logic                 bit_clk,
  input logic                 word_clk,
  input logic                 ser_x,
  input logic                 ser_y
);

  AST_SERX_ON_BIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_x) |-> $rose(bit_clk)); // R3

  AST_SERY_ON_BIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_y) |-> $rose(bit_clk)); // R3

  AST_WORD_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_clk) |-> ($rose(bit_clk) && !ser_x && !ser_y)); // R5

  AST_WORD_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_clk) |-> $rose(bit_clk)); // R5

  AST_ADDR_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (addr_q == $past(addr_wdata))); // R7

  AST_ADDR_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> $stable(addr_q)); // R7

  AST_SRC_ADDR_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_addr) |-> ($rose(bit_clk) && !word_clk && src_addr == $past(addr_q))); // R8

endmodule

bind eye_pattern_serializer eye_ser_checker #(.ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_we    (addr_we),
  .addr_wdata (addr_wdata),
  .addr_q     (addr_q),
  .src_addr   (src_addr),
  .src_x      (src_x),
  .src_y      (src_y),
  .bit_clk    (bit_clk),
  .word_clk   (word_clk),
  .ser_x      (ser_x),
  .ser_y      (ser_y)
);

// File: tb/eye_pattern_serializer_test.sv
module eye_pattern_serializer_test;

  localparam int CPB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_we = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic [7:0] addr_q, src_addr;
  logic [8:0] src_x, src_y;
  logic       bit_clk, word_clk, ser_x, ser_y;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [8:0] fx(input logic [7:0] a);
    return 9'(a * 7 + 3);
  endfunction
  function automatic logic [8:0] fy(input logic [7:0] a);
    return 9'({a, 1'b1} ^ 9'h0AA);
  endfunction

  // sample RAM model: asynchronous read
  assign src_x = fx(src_addr);
  assign src_y = fy(src_addr);

  eye_pattern_serializer #(.CLK_PER_BIT(CPB)) uut (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .addr_q(addr_q), .src_addr(src_addr), .src_x(src_x), .src_y(src_y),
    .bit_clk(bit_clk), .word_clk(word_clk), .ser_x(ser_x), .ser_y(ser_y)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns at the negedge right after bit_clk rose; cyc = system cycles waited
  task automatic next_bit_rise(output int cyc);
    logic p;
    p = bit_clk;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (bit_clk && !p) break;
      p = bit_clk;
    end
  endtask

  task automatic host_write(input logic [7:0] a);
    addr_we = 1'b1;
    addr_wdata = a;
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  // capture one frame; if in_last is set the caller sits in slot 23 already
  task automatic capture(input bit in_last, output logic [8:0] x, output logic [8:0] y,
                         output bit tail_zero, output int w_on, output int w_off);
    int c;
    logic pw;
    if (!in_last) begin
      pw = word_clk;
      forever begin
        @(negedge clk);
        if (pw && !word_clk) break;
        pw = word_clk;
      end
      for (int k = 0; k < 2; k++) next_bit_rise(c);  // now in slot 23
    end
    tail_zero = 1'b1;
    w_on = -1;
    w_off = -1;
    for (int s = 0; s < 24; s++) begin
      next_bit_rise(c);
      if (s < 9) begin
        x[8-s] = ser_x;
        y[8-s] = ser_y;
      end else if (ser_x || ser_y) tail_zero = 1'b0;
      if (word_clk && w_on < 0) w_on = s;
      if (!word_clk && w_on >= 0 && w_off < 0) w_off = s;
    end
    for (int k = 0; k < 0; k++) next_bit_rise(c);
    // leaves caller in slot 23 of the captured frame
  endtask

  // stimulus vectors: address to display, and whether to write it in slot 23
  typedef struct packed { logic [7:0] addr; logic defer; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h00, 1'b0}, '{8'hFF, 1'b0}, '{8'h80, 1'b0},
    '{8'h3C, 1'b1}, '{8'hA5, 1'b0}, '{8'h5A, 1'b1}
  };

  initial begin
    logic [8:0] x, y;
    logic [7:0] cur;
    bit tz;
    int won, woff, c, hi;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 bit_clk", bit_clk, 0);
    chk("R1 word_clk", word_clk, 0);
    chk("R1 ser", {ser_x, ser_y}, 0);
    chk("R1 addr_q", addr_q, 8'h17);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 src_addr", src_addr, 8'h17);

    // R2: bit clock shape
    next_bit_rise(c);
    hi = 0;
    while (bit_clk) begin hi++; @(negedge clk); end
    next_bit_rise(c);
    chk("R2 high cycles", hi, CPB / 2);
    chk("R2 period", c + hi, CPB);

    // default frame: R4 R5 R6
    capture(1'b0, x, y, tz, won, woff);
    chk("R6 x default", x, fx(8'h17));
    chk("R6 y default", y, fy(8'h17));
    chk("R4 tail zero", tz, 1);
    chk("R5 word rise slot", won, 9);
    chk("R5 word fall slot", woff, 21);
    cur = 8'h17;

    // vector walk
    foreach (VECS[i]) begin
      if (!VECS[i].defer) begin
        // R8: write mid-frame, the next frame shows it
        for (int k = 0; k < 4; k++) next_bit_rise(c);
        host_write(VECS[i].addr);
        chk("R7 addr_q", addr_q, VECS[i].addr);
        capture(1'b0, x, y, tz, won, woff);
        chk("R8 x", x, fx(VECS[i].addr));
        chk("R8 y", y, fy(VECS[i].addr));
        chk("R4 tail", tz, 1);
        chk("R5 rise", won, 9);
      end else begin
        // R9: write in slot 23, one frame of old data first
        host_write(VECS[i].addr);
        chk("R7 addr_q", addr_q, VECS[i].addr);
        capture(1'b1, x, y, tz, won, woff);
        chk("R9 old x", x, fx(cur));
        chk("R9 old y", y, fy(cur));
        capture(1'b1, x, y, tz, won, woff);
        chk("R9 new x", x, fx(VECS[i].addr));
        chk("R9 new y", y, fy(VECS[i].addr));
        chk("R5 fall", woff, 21);
      end
      cur = VECS[i].addr;
    end

    // R3: no line change at a cycle without a bit_clk rise (directed, one frame)
    begin
      logic px, py, pb;
      bit ok;
      ok = 1'b1;
      px = ser_x; py = ser_y; pb = bit_clk;
      repeat (24 * CPB) begin
        @(negedge clk);
        if (((ser_x != px) || (ser_y != py)) && !(bit_clk && !pb)) ok = 1'b0;
        px = ser_x; py = ser_y; pb = bit_clk;
      end
      chk("R3 change only on bit rise", ok, 1);
    end

    // R1: reset again mid-frame restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset addr", addr_q, 8'h17);
    chk("R1 re-reset outs", {bit_clk, word_clk, ser_x, ser_y}, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule